// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

A purely combinational 32-bit binary adder. It takes two 32-bit operands and a carry-in, and returns a 32-bit sum and a carry-out equal to `a + b + cin`. The operand is cut into seven carry-select groups whose widths grow from the least significant end toward the most significant end. Every group except the lowest prepares two candidate results in parallel: one for an incoming carry of 0 and one for an incoming carry of 1. A 2:1 selection then picks one of them as soon as the carry from the group below settles. The lengths of the local carry chains are chosen so that each one finishes at about the time its select carry arrives.

The parameter `USE_BEC` picks how the carry-in-1 candidate is formed. With `USE_BEC = 0`, each group has a second ripple chain whose lowest carry input is tied high. With `USE_BEC = 1`, the second chain is replaced by an increment-by-one circuit that acts on the carry-in-0 candidate (group sum bits together with the group carry). Both variants are drop-in replacements for each other and produce identical outputs.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, `{cout, sum}` equals the 33-bit value `a + b + cin`, in both variants.
- R2: The groups, from least to most significant, are 2, 3, 4, 5, 5, 6 and 7 bits wide. Their lowest bits are at positions 0, 2, 5, 9, 14, 19 and 25.
- R3: The lowest group is a single ripple adder fed directly by `cin`, with no selection. With `a = b = 0` and `cin = 1`, the result is `sum = 1`, `cout = 0`.
- R4: The carry entering each upper group selects that group's result: 1 picks the carry-in-1 candidate and 0 picks the carry-in-0 candidate, for both the sum bits and the group carry. A carry generated just below any group boundary reaches the sum bits above it.
- R5: With `USE_BEC = 0`, the carry-in-1 candidate of each group comes from a second ripple chain whose bit-0 carry input is tied to 1.
- R6: With `USE_BEC = 1`, the carry-in-1 candidate of an n-bit group is the (n+1)-bit carry-in-0 candidate plus one. Output bit 0 is the inverse of input bit 0, and output bit i is input bit i XOR the AND of all lower input bits.
- R7: `cout` is the selected group carry of the top group. All-ones operands with `cin = 1` give `sum = 32'hFFFFFFFF`, `cout = 1`, and `a = 32'hFFFFFFFF`, `b = 0`, `cin = 1` gives `sum = 0`, `cout = 1`.
- R8: All-zero operands with `cin = 0` give `sum = 0`, `cout = 0`.
- R9: For the same inputs, the two variants give bit-identical `sum` and `cout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Sum bits |
| cout | output | 1 | Carry out of bit 31 |

## Verification
The block holds no state, so a wrong internal value shows at the ports in the same evaluation as the stimulus that exposes it. A bad candidate in one group corrupts only that group's sum slice and the carry it passes upward, and only when the select carry picks that candidate. Because of this, the stimulus places generate-and-propagate patterns at every group boundary, with `cin` both 0 and 1, so that each candidate of each group is picked at least once. The same stimulus is applied to both variants side by side, which catches a fault in either the second ripple chain or the incrementer.

// File: rtl/sqcsa_pkg.sv
// Package: shared geometry of the square-root carry-select adder.
// Holds the group widths, least significant first, and derives from them the
// bit offsets and the total datapath width. Nothing here is clocked.
package sqcsa_pkg;

    localparam int NGRP = 7;
    localparam int GRP_W [NGRP] = '{2, 3, 4, 5, 5, 6, 7};

    // Lowest operand bit belonging to group g.
    function automatic int grp_lo(input int g);
        int acc;
        acc = 0;
        for (int i = 0; i < g; i++) begin
            acc += GRP_W[i];
        end
        return acc;
    endfunction

    localparam int ADD_W  = grp_lo(NGRP);
    // Flattened candidate buses hold n+1 bits per n-bit group.
    localparam int CAND_W = ADD_W + NGRP;

    // Offset of group g's candidate field inside a flattened candidate bus.
    function automatic int cand_lo(input int g);
        return grp_lo(g) + g;
    endfunction

endpackage

// File: rtl/sqcsa_rca.sv
// Module: sqcsa_rca
// Ripple-carry adder of W bits with an explicit carry input.
// Assumes W >= 1. Purely combinational; the carry walks one bit per stage.
module sqcsa_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);

    logic [W:0] c;

    // Entry of the carry chain.
    assign c[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // One full-adder cell: sum bit and the carry into the next position.
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign co = c[W];

endmodule

// File: rtl/sqcsa_bec.sv
// Module: sqcsa_bec
// Binary-to-excess-one converter: dout = din + 1, modulo 2**N.
// Bit 0 is inverted, and each higher bit flips when all bits below it are 1.
// Assumes N >= 2. Purely combinational.
module sqcsa_bec #(
    parameter int N = 4
) (
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    // lo_ones[i] is 1 when din[i-1:0] is all ones.
    logic [N-1:0] lo_ones;

    // Bit 0 always toggles.
    assign lo_ones[0] = 1'b1;
    assign dout[0]    = ~din[0];

    for (genvar i = 1; i < N; i++) begin : g_bit
        // Prefix AND of the lower bits, then a conditional toggle.
        assign lo_ones[i] = lo_ones[i-1] & din[i-1];
        assign dout[i]    = din[i] ^ lo_ones[i];
    end

endmodule

// File: rtl/sqcsa_group.sv
// Module: sqcsa_group
// One carry-select group of W bits. It forms a carry-in-0 candidate with a
// ripple adder and a carry-in-1 candidate either with a second ripple adder
// whose carry input is tied high (USE_BEC = 0) or by incrementing the
// carry-in-0 candidate (USE_BEC = 1). sel, the carry from the group below,
// picks the candidate for both the sum bits and the group carry.
// Assumes W >= 1.
module sqcsa_group #(
    parameter int W       = 4,
    parameter bit USE_BEC = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel,
    output logic [W-1:0] s,
    output logic         co,
    output logic [W:0]   cand0,
    output logic [W:0]   cand1
);

    logic [W-1:0] s_zero;
    logic         c_zero;

    // Candidate assuming no carry enters the group.
    sqcsa_rca #(.W(W)) u_rca0 (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .s  (s_zero),
        .co (c_zero)
    );

    assign cand0 = {c_zero, s_zero};

    if (USE_BEC) begin : g_inc
        // Candidate assuming a carry enters: carry-in-0 result plus one.
        sqcsa_bec #(.N(W + 1)) u_bec (
            .din  (cand0),
            .dout (cand1)
        );
    end else begin : g_dual
        logic [W-1:0] s_one;
        logic         c_one;

        // Candidate assuming a carry enters: second chain, carry tied high.
        sqcsa_rca #(.W(W)) u_rca1 (
            .a  (a),
            .b  (b),
            .ci (1'b1),
            .s  (s_one),
            .co (c_one)
        );

        assign cand1 = {c_one, s_one};
    end

    // Final 2:1 selection on the incoming carry.
    assign {co, s} = sel ? cand1 : cand0;

endmodule

// File: rtl/sqrt_csel_adder.sv
// Module: sqrt_csel_adder (top)
// 32-bit square-root carry-select adder: {cout, sum} = a + b + cin.
// Group widths come from sqcsa_pkg. The lowest group is a plain ripple adder
// driven by cin; each higher group is a carry-select group steered by the
// carry of the group below. USE_BEC picks the carry-in-1 candidate source.
// Purely combinational; no clock or reset.
module sqrt_csel_adder
    import sqcsa_pkg::*;
#(
    parameter bit USE_BEC = 1'b1
) (
    input  logic [ADD_W-1:0] a,
    input  logic [ADD_W-1:0] b,
    input  logic             cin,
    output logic [ADD_W-1:0] sum,
    output logic             cout
);

    // grp_carry[g] is the carry entering group g; grp_carry[NGRP] leaves the top.
    logic [NGRP:0]     grp_carry;
    logic [CAND_W-1:0] cand0_flat;
    logic [CAND_W-1:0] cand1_flat;

    // External carry feeds the lowest group.
    assign grp_carry[0] = cin;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int W  = GRP_W[g];
        localparam int LO = grp_lo(g);
        localparam int CL = cand_lo(g);

        if (g == 0) begin : g_base
            // Lowest group: one ripple adder, no selection.
            sqcsa_rca #(.W(W)) u_rca (
                .a  (a[LO +: W]),
                .b  (b[LO +: W]),
                .ci (grp_carry[g]),
                .s  (sum[LO +: W]),
                .co (grp_carry[g+1])
            );
            // Both candidate fields carry the single result of this group.
            assign cand0_flat[CL +: W+1] = {grp_carry[g+1], sum[LO +: W]};
            assign cand1_flat[CL +: W+1] = {grp_carry[g+1], sum[LO +: W]};
        end else begin : g_sel
            // Upper group: two candidates selected by the carry from below.
            sqcsa_group #(.W(W), .USE_BEC(USE_BEC)) u_group (
                .a     (a[LO +: W]),
                .b     (b[LO +: W]),
                .sel   (grp_carry[g]),
                .s     (sum[LO +: W]),
                .co    (grp_carry[g+1]),
                .cand0 (cand0_flat[CL +: W+1]),
                .cand1 (cand1_flat[CL +: W+1])
            );
        end
    end

    // Carry out is the selected carry of the top group.
    assign cout = grp_carry[NGRP];

endmodule

// File: rtl/sqcsa_chk.sv
// Module: sqcsa_chk
// Property checker bound to sqrt_csel_adder. It observes the ports together
// with the internal group carries and candidate buses, and relates them to
// plain arithmetic. Because the adder is combinational, the checks are
// immediate assertions evaluated whenever the inputs are known.
module sqcsa_chk
    import sqcsa_pkg::*;
(
    input logic [ADD_W-1:0]  a,
    input logic [ADD_W-1:0]  b,
    input logic              cin,
    input logic [ADD_W-1:0]  sum,
    input logic              cout,
    input logic [NGRP:0]     grp_carry,
    input logic [CAND_W-1:0] cand0_flat,
    input logic [CAND_W-1:0] cand1_flat
);

    // Whole-word result against arithmetic (R1, R7).
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            a_r1_total_sum: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{ADD_W{1'b0}}, cin}))
                else $error("a_r1_total_sum violated");
            a_r3_low_bit: assert (sum[0] == (a[0] ^ b[0] ^ cin))
                else $error("a_r3_low_bit violated");
        end
    end

    for (genvar g = 1; g < NGRP; g++) begin : g_grp
        localparam int W  = GRP_W[g];
        localparam int L  = grp_lo(g);
        localparam int CL = cand_lo(g);
        localparam logic [ADD_W:0] MASK = (ADD_W+1)'((64'd1 << L) - 64'd1);

        logic [ADD_W:0] low_part;
        logic [W:0]     c0;
        logic [W:0]     c1;

        // Per-group relations between candidates, boundary carry and output.
        always_comb begin
            low_part = ({1'b0, a} & MASK) + ({1'b0, b} & MASK) + {{ADD_W{1'b0}}, cin};
            c0       = cand0_flat[CL +: W+1];
            c1       = cand1_flat[CL +: W+1];
            if (!$isunknown({a, b, cin})) begin
                a_r2_boundary_carry: assert (grp_carry[g] == low_part[L])
                    else $error("a_r2_boundary_carry violated in group %0d", g);
                a_r6_cand_step: assert (c1 == c0 + 1'b1)
                    else $error("a_r6_cand_step violated in group %0d", g);
                a_r4_pick: assert ({grp_carry[g+1], sum[L +: W]} == (grp_carry[g] ? c1 : c0))
                    else $error("a_r4_pick violated in group %0d", g);
                a_r4_carry_order: assert (!c0[W] || c1[W])
                    else $error("a_r4_carry_order violated in group %0d", g);
            end
        end
    end

endmodule

bind sqrt_csel_adder sqcsa_chk u_chk (
    .a          (a),
    .b          (b),
    .cin        (cin),
    .sum        (sum),
    .cout       (cout),
    .grp_carry  (grp_carry),
    .cand0_flat (cand0_flat),
    .cand1_flat (cand1_flat)
);

// File: tb/sim_sqrt_csel_adder.sv
// Bench for sqrt_csel_adder: drives both variants with the same vectors on
// every clock and compares each against a behavioural model held in a queue.
module sim_sqrt_csel_adder;

    localparam int AW = 32;

    logic          clk;
    logic          rst_n;
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    logic          cin;
    logic [AW-1:0] sum_bec;
    logic          cout_bec;
    logic [AW-1:0] sum_rip;
    logic          cout_rip;

    int  n_vec;
    int  n_bad;
    bit  done;

    // Expected results waiting for comparison.
    logic [AW:0] exp_q [$];
    string       tag_q [$];

    sqrt_csel_adder #(.USE_BEC(1'b1)) u0 (
        .a (a), .b (b), .cin (cin), .sum (sum_bec), .cout (cout_bec)
    );

    sqrt_csel_adder #(.USE_BEC(1'b0)) u1 (
        .a (a), .b (b), .cin (cin), .sum (sum_rip), .cout (cout_rip)
    );

    // 125 MHz clock.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Behavioural model of the addition, in integer arithmetic.
    function automatic logic [AW:0] model(input logic [AW-1:0] x, input logic [AW-1:0] y,
                                          input logic c);
        longint unsigned t;
        t = longint'(x) + longint'(y) + longint'(c);
        return t[AW:0];
    endfunction

    // Drive one vector at a rising edge; compare at the following falling edge.
    task automatic apply(input logic [AW-1:0] x, input logic [AW-1:0] y,
                         input logic c, input string tag);
        logic [AW:0] e;
        string       t;
        @(posedge clk);
        a   <= x;
        b   <= y;
        cin <= c;
        exp_q.push_back(model(x, y, c));
        tag_q.push_back(tag);
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if ({cout_bec, sum_bec} !== e) begin
            n_bad++;
            $display("FAIL %s incrementer variant: a=%h b=%h cin=%b got %h expected %h",
                     t, x, y, c, {cout_bec, sum_bec}, e);
        end
        if ({cout_rip, sum_rip} !== e) begin
            n_bad++;
            $display("FAIL %s ripple variant: a=%h b=%h cin=%b got %h expected %h",
                     t, x, y, c, {cout_rip, sum_rip}, e);
        end
        if ({cout_bec, sum_bec} !== {cout_rip, sum_rip}) begin
            n_bad++;
            $display("FAIL R9 variants differ: got %h expected %h",
                     {cout_bec, sum_bec}, {cout_rip, sum_rip});
        end
    endtask

    // Watchdog: an expired run counts as a miscompare.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        int bounds [6] = '{2, 5, 9, 14, 19, 25};
        n_vec = 0;
        n_bad = 0;
        done  = 1'b0;
        rst_n = 1'b0;
        a     = '0;
        b     = '0;
        cin   = 1'b0;
        repeat (3) @(posedge clk);
        // Reset state: zero inputs give zero outputs (R8).
        @(negedge clk);
        n_vec++;
        if ({cout_bec, sum_bec} !== '0 || {cout_rip, sum_rip} !== '0) begin
            n_bad++;
            $display("FAIL R8 reset: got %h / %h expected 0",
                     {cout_bec, sum_bec}, {cout_rip, sum_rip});
        end
        rst_n = 1'b1;

        apply('0, '0, 1'b0, "R8");
        apply('0, '0, 1'b1, "R3");
        apply(32'h1, '0, 1'b1, "R3");
        apply('1, '1, 1'b0, "R7");
        apply('1, '1, 1'b1, "R7");
        apply('1, '0, 1'b1, "R7");
        apply('0, '1, 1'b1, "R7");
        apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R7");
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R1");
        apply(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R1");

        // Carry generated just below each boundary and propagated above it
        // (R2, R4); also a boundary with the carry only just absent.
        foreach (bounds[k]) begin
            int p;
            p = bounds[k];
            apply(32'hFFFF_FFFF << (p - 1), 32'h1 << (p - 1), 1'b0, "R4");
            apply(32'hFFFF_FFFF << (p - 1), 32'h1 << (p - 1), 1'b1, "R4");
            apply((32'h1 << p) - 1, 32'h0, 1'b1, "R2");
            apply((32'h1 << p) - 2, 32'h0, 1'b1, "R2");
            apply(32'h1 << p, 32'h1 << p, 1'b0, "R2");
        end

        // Each upper group fully propagating with and without an incoming carry
        // exercises both candidates of both variants (R5, R6).
        foreach (bounds[k]) begin
            int p;
            p = bounds[k];
            apply(32'hFFFF_FFFF, 32'h1 << p, 1'b0, "R5");
            apply(32'hFFFF_FFFF >> (32 - p), 32'h0, 1'b1, "R6");
        end

        // Random vectors with both carry-in values (R1, R9).
        for (int i = 0; i < 3000; i++) begin
            apply($urandom, $urandom, 1'($urandom), "R1");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule